// File: doc/BRIEF.md
# Overcurrent Pulse-Skip and Peak-Limit Foldback Controller

This block guards the high-side switch of a step-down converter against overload, one switching period at a time. A tick marks the start of each period and a gate request comes from the PWM comparator. The block passes that request on as a gate enable. It ignores the overcurrent comparator for a blanking window after turn-on. When the window closes it samples the comparator, and a high reading ends the pulse at once.

Each overcurrent sample raises a skip level, which saturates at a set maximum. After such a sample, that many whole periods follow with the gate held low, so the effective switching frequency falls steadily under sustained overload. A period that is clean when blanking ends lowers the level by one.

Beside this, the block outputs the peak-limit code for the current-limit DAC. When the output is shorted, shown by the feedback-low flag, it picks one third of the programmed code. This foldback is not applied while soft-start runs. The code never goes below a floor that stands for the pulse-skip current.

Top module: `ocp_skip_foldback`

## Requirements
- R1: After reset, `gate_en` is low until the first `cycle_tick`. `gate_en` is high only when `enable` and `gate_req` are both high in a period that was not skipped, and for at most one pulse per period. A pulse begins in the first clock of the period in which `gate_req` is high.
- R2: The overcurrent flag has no effect during the first BLANK_CYC clocks of a pulse (clock indices 0 to BLANK_CYC-1 from turn-on). A pulse that sees overcurrent all through blanking still drives the gate for exactly BLANK_CYC clocks.
- R3: If `oc_flag` is high in the clock at index BLANK_CYC (end of blanking), `gate_en` is low in that same clock and for the rest of the period.
- R4: If `oc_flag` rises at any clock after index BLANK_CYC, the pulse ends in that clock. The sample already taken at the end of blanking counts as clean.
- R5: An overcurrent sample at the end of blanking raises the skip level by one, up to SKIP_MAX (default 7). The next skip-level periods then keep `gate_en` low for the whole period. With overload at every active pulse and the level saturated, one period in SKIP_MAX+1 switches.
- R6: A clean sample at the end of blanking lowers the skip level by one. The level does not go below zero.
- R7: A pulse whose `gate_req` falls before index BLANK_CYC takes no sample and leaves the skip level unchanged.
- R8: While `enable` is low, `gate_en` is low. The skip level and the pending skip count are cleared one clock later, so the first period after re-enable is not skipped.
- R9: `lim_code` is registered and follows the inputs of the previous clock. With `fb_low` high and `ss_active` low, it is `lim_prog / 3` using integer division. Otherwise it is `lim_prog`.
- R10: While `ss_active` is high, `fb_low` has no effect on `lim_code`.
- R11: `lim_code` is never below FLOOR_CODE (default 4). Any smaller result, folded or not, is raised to FLOOR_CODE. The reset value is FLOOR_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low clears skip state and blocks the gate |
| cycle_tick | input | 1 | One-clock pulse that starts each switching period |
| gate_req | input | 1 | High-side on request from the PWM stage |
| oc_flag | input | 1 | Overcurrent comparator output |
| fb_low | input | 1 | Feedback below the short-circuit fold level |
| ss_active | input | 1 | Soft-start in progress |
| lim_prog | input | LIM_W | Programmed peak-limit code |
| gate_en | output | 1 | Gated high-side enable |
| lim_code | output | LIM_W | Peak-limit code applied to the limit DAC |

## Verification
The bound assertions check, on every clock, that the gate never opens without a request and an enable, and that it closes in the very clock of an overcurrent sample. They also check the skip level's one-step moves and its saturation, that the pending skips are reloaded from the new level, that disable clears state, that the limit never drops under the floor, and the fold and soft-start selection of the limit code. Only the bench's period-by-period scenarios can show the pulse widths, that is, whole skipped periods and blanking that spans exactly BLANK_CYC clocks. The same holds for the one-in-eight switching ratio under sustained overload, the gradual recovery, and the lack of any effect from short pulses and late trips on the skip level.

// File: rtl/ocpf_pkg.sv
package ocpf_pkg;

    // Phase of the current switching period as seen by the pulse gate.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // no period yet, disabled, or period skipped
        PH_WAIT = 2'd1,  // active period, pulse not started
        PH_ON   = 2'd2,  // pulse running (blanking or post-blanking)
        PH_DONE = 2'd3   // pulse finished for this period
    } ocpf_phase_e;

endpackage

// File: rtl/ocpf_pulse_ctrl.sv
module ocpf_pulse_ctrl
    import ocpf_pkg::*;
#(
    parameter int BLANK_CYC = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cycle_tick,
    input  logic skip_pending,
    input  logic gate_req,
    input  logic oc_flag,
    output logic gate_en,
    output logic sample_stb,
    output logic sample_oc
);

    localparam int CNT_W = $clog2(BLANK_CYC + 2);
    localparam logic [CNT_W-1:0] BLANK_END = CNT_W'(BLANK_CYC);
    localparam logic [CNT_W-1:0] POST_BLANK = CNT_W'(BLANK_CYC + 1);

    typedef struct packed {
        ocpf_phase_e      phase;
        logic [CNT_W-1:0] cnt;
    } pulse_state_t;

    pulse_state_t st_d, st_q;
    logic         blank_over;
    logic         trip_now;

    always_comb begin
        st_d       = st_q;
        blank_over = (st_q.cnt >= BLANK_END);
        trip_now   = blank_over && oc_flag;

        gate_en    = enable && gate_req &&
                     ((st_q.phase == PH_WAIT) ||
                      ((st_q.phase == PH_ON) && !trip_now));
        sample_stb = enable && !cycle_tick && gate_req &&
                     (st_q.phase == PH_ON) && (st_q.cnt == BLANK_END);
        sample_oc  = oc_flag;

        if (!enable) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else if (cycle_tick) begin
            st_d.phase = skip_pending ? PH_IDLE : PH_WAIT;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.phase)
                PH_WAIT: begin
                    if (gate_req) begin
                        st_d.phase = PH_ON;
                        st_d.cnt   = CNT_W'(1);
                    end
                end
                PH_ON: begin
                    if (!gate_req) begin
                        st_d.phase = PH_DONE;
                    end else if (st_q.cnt == BLANK_END) begin
                        if (oc_flag) st_d.phase = PH_DONE;
                        else         st_d.cnt   = POST_BLANK;
                    end else if (st_q.cnt == POST_BLANK) begin
                        if (oc_flag) st_d.phase = PH_DONE;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ocpf_skip_ctrl.sv
module ocpf_skip_ctrl #(
    parameter int SKIP_MAX = 7,
    localparam int SKIP_W = $clog2(SKIP_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cycle_tick,
    input  logic              sample_stb,
    input  logic              sample_oc,
    output logic              skip_pending,
    output logic [SKIP_W-1:0] skip_lvl,
    output logic [SKIP_W-1:0] skip_left
);

    localparam logic [SKIP_W-1:0] LVL_TOP = SKIP_W'(SKIP_MAX);

    typedef struct packed {
        logic [SKIP_W-1:0] lvl;
        logic [SKIP_W-1:0] left;
    } skip_state_t;

    skip_state_t sk_d, sk_q;

    always_comb begin
        sk_d         = sk_q;
        skip_pending = (sk_q.left != '0);

        if (!enable) begin
            sk_d.lvl  = '0;
            sk_d.left = '0;
        end else if (cycle_tick) begin
            if (skip_pending) sk_d.left = sk_q.left - SKIP_W'(1);
        end else if (sample_stb) begin
            if (sample_oc) begin
                sk_d.lvl  = (sk_q.lvl == LVL_TOP) ? LVL_TOP : sk_q.lvl + SKIP_W'(1);
                sk_d.left = sk_d.lvl;
            end else begin
                sk_d.lvl  = (sk_q.lvl == '0) ? '0 : sk_q.lvl - SKIP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_q.lvl  <= '0;
            sk_q.left <= '0;
        end else begin
            sk_q <= sk_d;
        end
    end

    assign skip_lvl  = sk_q.lvl;
    assign skip_left = sk_q.left;

endmodule

// File: rtl/ocpf_limit_sel.sv
module ocpf_limit_sel #(
    parameter int LIM_W      = 6,
    parameter int FLOOR_CODE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LIM_W-1:0] lim_prog,
    input  logic             fb_low,
    input  logic             ss_active,
    output logic [LIM_W-1:0] lim_code
);

    localparam logic [LIM_W-1:0] FLOOR = LIM_W'(FLOOR_CODE);
    localparam logic [LIM_W-1:0] DIV3  = LIM_W'(3);

    typedef struct packed {
        logic [LIM_W-1:0] code;
    } lim_state_t;

    lim_state_t       lm_d, lm_q;
    logic             fold_on;
    logic [LIM_W-1:0] third;
    logic [LIM_W-1:0] cand;

    always_comb begin
        fold_on = fb_low && !ss_active;
        third   = lim_prog / DIV3;
        cand    = fold_on ? third : lim_prog;
        lm_d.code = (cand < FLOOR) ? FLOOR : cand;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lm_q.code <= FLOOR;
        else        lm_q      <= lm_d;
    end

    assign lim_code = lm_q.code;

endmodule

// File: rtl/ocp_skip_foldback.sv
module ocp_skip_foldback #(
    parameter int BLANK_CYC  = 15,
    parameter int SKIP_MAX   = 7,
    parameter int LIM_W      = 6,
    parameter int FLOOR_CODE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cycle_tick,
    input  logic             gate_req,
    input  logic             oc_flag,
    input  logic             fb_low,
    input  logic             ss_active,
    input  logic [LIM_W-1:0] lim_prog,
    output logic             gate_en,
    output logic [LIM_W-1:0] lim_code
);

    localparam int SKIP_W = $clog2(SKIP_MAX + 1);

    logic              skip_pending;
    logic              sample_stb;
    logic              sample_oc;
    logic [SKIP_W-1:0] skip_lvl;
    logic [SKIP_W-1:0] skip_left;

    ocpf_pulse_ctrl #(.BLANK_CYC(BLANK_CYC)) pulse_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cycle_tick  (cycle_tick),
        .skip_pending(skip_pending),
        .gate_req    (gate_req),
        .oc_flag     (oc_flag),
        .gate_en     (gate_en),
        .sample_stb  (sample_stb),
        .sample_oc   (sample_oc)
    );

    ocpf_skip_ctrl #(.SKIP_MAX(SKIP_MAX)) skip_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cycle_tick  (cycle_tick),
        .sample_stb  (sample_stb),
        .sample_oc   (sample_oc),
        .skip_pending(skip_pending),
        .skip_lvl    (skip_lvl),
        .skip_left   (skip_left)
    );

    ocpf_limit_sel #(.LIM_W(LIM_W), .FLOOR_CODE(FLOOR_CODE)) limit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lim_prog (lim_prog),
        .fb_low   (fb_low),
        .ss_active(ss_active),
        .lim_code (lim_code)
    );

endmodule

// File: rtl/ocpf_checker.sv
module ocpf_checker #(
    parameter int SKIP_MAX   = 7,
    parameter int LIM_W      = 6,
    parameter int FLOOR_CODE = 4,
    localparam int SKIP_W = $clog2(SKIP_MAX + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              gate_req,
    input logic              gate_en,
    input logic              fb_low,
    input logic              ss_active,
    input logic [LIM_W-1:0]  lim_prog,
    input logic [LIM_W-1:0]  lim_code,
    input logic              sample_stb,
    input logic              sample_oc,
    input logic [SKIP_W-1:0] skip_lvl,
    input logic [SKIP_W-1:0] skip_left
);

    localparam logic [LIM_W-1:0] FLOOR = LIM_W'(FLOOR_CODE);

    p_gate_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> (gate_req && enable));

    p_trip_same_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && sample_oc) |-> !gate_en);

    p_level_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_lvl <= SKIP_W'(SKIP_MAX)) && (skip_left <= skip_lvl));

    p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && sample_oc) |=>
            (skip_lvl == (($past(skip_lvl) == SKIP_W'(SKIP_MAX)) ?
                          SKIP_W'(SKIP_MAX) : $past(skip_lvl) + SKIP_W'(1))));

    p_reload_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && sample_oc) |=> (skip_left == skip_lvl));

    p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !sample_oc) |=>
            (skip_lvl == (($past(skip_lvl) == '0) ? '0 : $past(skip_lvl) - SKIP_W'(1))));

    p_clear_on_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (skip_lvl == '0) && (skip_left == '0));

    p_fold_third_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fb_low) && !$past(ss_active)) |->
            (lim_code == ((($past(lim_prog) / 3) < FLOOR) ? FLOOR : ($past(lim_prog) / 3))));

    p_no_fold_in_ss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ss_active)) |->
            (lim_code == (($past(lim_prog) < FLOOR) ? FLOOR : $past(lim_prog))));

    p_limit_floor_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lim_code >= FLOOR);

endmodule

bind ocp_skip_foldback ocpf_checker #(
    .SKIP_MAX  (SKIP_MAX),
    .LIM_W     (LIM_W),
    .FLOOR_CODE(FLOOR_CODE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .gate_req  (gate_req),
    .gate_en   (gate_en),
    .fb_low    (fb_low),
    .ss_active (ss_active),
    .lim_prog  (lim_prog),
    .lim_code  (lim_code),
    .sample_stb(sample_stb),
    .sample_oc (sample_oc),
    .skip_lvl  (skip_lvl),
    .skip_left (skip_left)
);

// File: tb/ocp_skip_foldback_tb.sv
`timescale 1ns/1ps
module ocp_skip_foldback_tb_top;

    localparam int B     = 15;
    localparam int SMAX  = 7;
    localparam int LW    = 6;
    localparam int FLOOR = 4;
    localparam int LEN   = B + 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enable;
    logic          cycle_tick;
    logic          gate_req;
    logic          oc_flag;
    logic          fb_low;
    logic          ss_active;
    logic [LW-1:0] lim_prog;
    logic          gate_en;
    logic [LW-1:0] lim_code;

    int  n_chk = 0;
    int  n_err = 0;
    int  m_lvl = 0;
    int  m_left = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    ocp_skip_foldback #(
        .BLANK_CYC(B), .SKIP_MAX(SMAX), .LIM_W(LW), .FLOOR_CODE(FLOOR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cycle_tick(cycle_tick),
        .gate_req(gate_req), .oc_flag(oc_flag), .fb_low(fb_low),
        .ss_active(ss_active), .lim_prog(lim_prog),
        .gate_en(gate_en), .lim_code(lim_code)
    );

    function automatic int exp_lim(input int p, input bit f, input bit s);
        int v;
        v = (f && !s) ? p / 3 : p;
        return (v < FLOOR) ? FLOOR : v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One switching period: tick, gate request for len clocks with the
    // overcurrent flag high from index oc_from on, then two idle clocks.
    task automatic run_period(input int len, input int oc_from, input string tag,
                              output int on_cnt);
        int exp_on;
        on_cnt = 0;
        @(negedge clk);
        cycle_tick = 1'b1; gate_req = 1'b0; oc_flag = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            cycle_tick = 1'b0; gate_req = 1'b1; oc_flag = (i >= oc_from);
            #1;
            if (gate_en) on_cnt++;
        end
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            cycle_tick = 1'b0; gate_req = 1'b0; oc_flag = 1'b0;
            #1;
            if (gate_en) on_cnt++;
        end
        if (m_left > 0) begin
            m_left--;
            exp_on = 0;
        end else if (len <= B) begin
            exp_on = len;
        end else if (oc_from <= B) begin
            exp_on = B;
            m_lvl  = (m_lvl == SMAX) ? SMAX : m_lvl + 1;
            m_left = m_lvl;
        end else begin
            exp_on = (oc_from < len) ? oc_from : len;
            m_lvl  = (m_lvl == 0) ? 0 : m_lvl - 1;
        end
        chk(on_cnt == exp_on, tag, on_cnt, exp_on);
    endtask

    task automatic lim_step(input int p, input bit f, input bit s, input string tag);
        @(negedge clk);
        lim_prog = LW'(p); fb_low = f; ss_active = s;
        @(negedge clk);
        #1;
        chk(int'(lim_code) == exp_lim(p, f, s), tag, int'(lim_code), exp_lim(p, f, s));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int on_cnt;
        int active;
        void'($urandom(32'd4711));
        rst_n = 1'b0; enable = 1'b1; cycle_tick = 1'b0; gate_req = 1'b1;
        oc_flag = 1'b0; fb_low = 1'b0; ss_active = 1'b0; lim_prog = LW'(30);
        repeat (3) @(negedge clk);
        #1;
        chk(gate_en == 1'b0, "R1 gate low in reset", int'(gate_en), 0);
        chk(int'(lim_code) == FLOOR, "R11 limit reset value", int'(lim_code), FLOOR);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(gate_en == 1'b0, "R1 gate low before first tick", int'(gate_en), 0);
        gate_req = 1'b0;

        for (int k = 0; k < 3; k++) run_period(LEN, 99, "R1 clean period", on_cnt);

        // Sustained overload, overcurrent from turn-on (blanking hides it).
        active = 0;
        for (int k = 1; k <= 52; k++) begin
            run_period(LEN, 0, "R2 R5 sustained overload", on_cnt);
            if (k >= 37 && on_cnt != 0) active++;
        end
        chk(active == 2, "R5 one period in eight switches", active, 2);

        for (int k = 0; k < 30; k++) run_period(LEN, 99, "R6 recovery", on_cnt);

        run_period(LEN, B, "R3 trip at blanking end", on_cnt);
        for (int k = 0; k < 4; k++) run_period(LEN, B + 1, "R4 late trip", on_cnt);
        run_period(LEN, B + 2, "R4 late trip", on_cnt);
        run_period(B - 3, 0, "R7 short pulse no sample", on_cnt);
        run_period(B, 0, "R7 pulse ends at blanking", on_cnt);
        run_period(LEN, 0, "R7 after short pulses", on_cnt);

        // Build up skip state, then disable.
        for (int k = 0; k < 6; k++) run_period(LEN, 0, "R5 build level", on_cnt);
        @(negedge clk);
        enable = 1'b0; gate_req = 1'b1;
        #1;
        chk(gate_en == 1'b0, "R8 gate low while disabled", int'(gate_en), 0);
        @(negedge clk);
        enable = 1'b1; gate_req = 1'b0;
        m_lvl = 0; m_left = 0;
        run_period(LEN, 0, "R8 first period after re-enable", on_cnt);
        run_period(LEN, 99, "R8 level restarted from zero", on_cnt);

        for (int k = 0; k < 80; k++) begin
            int len;
            int ocf;
            len = B - 2 + int'($urandom_range(8));
            ocf = int'($urandom_range(B + 8));
            run_period(len, ocf, "R5 R6 random periods", on_cnt);
        end

        lim_step(30, 1'b0, 1'b0, "R9 full limit");
        lim_step(30, 1'b1, 1'b0, "R9 fold to third");
        lim_step(31, 1'b1, 1'b0, "R9 integer third");
        lim_step(30, 1'b1, 1'b1, "R10 soft-start blocks fold");
        lim_step(6,  1'b1, 1'b0, "R11 folded floor");
        lim_step(2,  1'b0, 1'b0, "R11 unfolded floor");
        lim_step(63, 1'b0, 1'b0, "R9 restore after fold");
        for (int k = 0; k < 200; k++) begin
            lim_step(int'($urandom_range(63)), 1'($urandom_range(1)),
                     1'($urandom_range(1)), "R9 R10 R11 random limit");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule